// File: doc/BRIEF.md
# Issue Queue Wakeup with Reducible Broadcast Width

This block holds dispatched instructions until both of their source operands are available. Each cycle up to four result tags arrive on broadcast lanes. Every waiting source tag is compared against each tag that is active in that cycle, and a hit on any lane marks the operand as ready. The block also offers the oldest ready entries for issue, up to a fixed issue width, and frees the entries that the downstream stage accepts.

A narrow-mode input lowers the number of comparisons per cycle from four to two, so that fewer compare paths switch while the core waits on a long cache miss. Tags that cannot be compared in the current cycle are not dropped. They wait in a small first-in first-out side buffer and are compared in later cycles, ahead of newer tags. When the side buffer cannot safely take a full cycle of surplus tags, the block raises a stall toward the tag source. One instance serves one register class, so a core uses one instance for integer operations and one for floating-point operations.

Top module: `iq_wakeup`

## Requirements
- R1: After reset no entry is valid. `rdy_vec_o`, `sel_vec_o`, `bc_stall_o` and `disp_full_o` are all zero.
- R2: When `disp_vld_i` is high and `disp_full_o` is low, the instruction is written into the lowest-numbered free entry at the clock edge. `disp_full_o` is high exactly when all DEPTH entries are valid, and a dispatch attempted while it is high is ignored.
- R3: A source operand counts as ready if its ready flag was set at dispatch, or if any tag compared in this or an earlier cycle of its residency equals it. Bit i of `rdy_vec_o` is high when entry i is valid and both of its operands are ready, including readiness gained from a tag compared in the same cycle.
- R4: In full mode (`reduce_i` = 0) with an empty side buffer, every valid lane of `bc_vld_i` is compared in the same cycle. Lane l carries its tag in `bc_tag_i[l*TAGW +: TAGW]`.
- R5: In narrow mode (`reduce_i` = 1) at most two tags are compared per cycle. Valid lanes beyond the available comparison slots are appended to the side buffer, taken in increasing lane index.
- R6: In any mode, tags already held in the side buffer take the comparison slots first, oldest first. Only the slots they leave unused go to new lanes. As a result, after a return to full mode the buffer drains before new tags are compared.
- R7: `bc_stall_o` is high whenever the side buffer holds more than ABUF minus LANES tags (more than 4 with the defaults). While it is high, the broadcast lanes are ignored, and the side buffer never exceeds ABUF tags.
- R8: `sel_vec_o` marks the IW (2) oldest entries in dispatch order whose `rdy_vec_o` bit is high. It never marks an entry that is not ready.
- R9: When `issue_go_i` is high, every entry marked in `sel_vec_o` is freed at that clock edge. This includes an entry that became ready in that same cycle. A freed slot cannot be reused by a dispatch in the same cycle.
- R10: A dispatched instruction's source tags are also compared against the tags compared in its dispatch cycle, so a wakeup in that cycle is not missed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reduce_i | input | 1 | Narrow broadcast mode (two comparisons per cycle) |
| bc_vld_i | input | LANES | Per-lane broadcast valid |
| bc_tag_i | input | LANES*TAGW | Broadcast tags, lane l at bits l*TAGW upward |
| bc_stall_o | output | 1 | Tag source must hold its broadcasts |
| disp_vld_i | input | 1 | Dispatch request |
| disp_tag_a_i | input | TAGW | First source tag |
| disp_rdy_a_i | input | 1 | First source already available |
| disp_tag_b_i | input | TAGW | Second source tag |
| disp_rdy_b_i | input | 1 | Second source already available |
| disp_full_o | output | 1 | No free entry |
| rdy_vec_o | output | DEPTH | Entries with both operands ready |
| sel_vec_o | output | DEPTH | Oldest ready entries offered for issue |
| issue_go_i | input | 1 | Downstream accepts the offered entries |

## Verification
A tag wakeup and an issue grant can fall in the same cycle. In that case an entry whose last operand is matched this cycle is already offered on `sel_vec_o` and is freed at the edge. The bench provokes this by broadcasting the missing tag while `issue_go_i` is high, and also by holding a dispatch and a matching broadcast together in one cycle. The behavioural model predicts the ready, select, stall and full outputs for every cycle, and the bench compares them with the design. Because the model frees only the entries it predicts as selected, a missed same-cycle wakeup or a stale free shows up as a mismatch.

// File: rtl/iq_wakeup.sv
module iq_wakeup #(
  parameter int DEPTH  = 32,
  parameter int TAGW   = 6,
  parameter int LANES  = 4,
  parameter int NARROW = 2,
  parameter int ABUF   = 8,
  parameter int IW     = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reduce_i,
  input  logic [LANES-1:0]      bc_vld_i,
  input  logic [LANES*TAGW-1:0] bc_tag_i,
  output logic                  bc_stall_o,
  input  logic                  disp_vld_i,
  input  logic [TAGW-1:0]       disp_tag_a_i,
  input  logic                  disp_rdy_a_i,
  input  logic [TAGW-1:0]       disp_tag_b_i,
  input  logic                  disp_rdy_b_i,
  output logic                  disp_full_o,
  output logic [DEPTH-1:0]      rdy_vec_o,
  output logic [DEPTH-1:0]      sel_vec_o,
  input  logic                  issue_go_i
);
  localparam int IDXW = $clog2(DEPTH);
  localparam int BPW  = $clog2(ABUF);
  localparam int CNTW = $clog2(ABUF + 1);
  localparam int NCMP = 2 * LANES;

  logic [DEPTH-1:0] vld_q, ra_q, rb_q;
  logic [TAGW-1:0]  ta_q [DEPTH];
  logic [TAGW-1:0]  tb_q [DEPTH];
  logic [DEPTH-1:0] older_q [DEPTH];
  logic [TAGW-1:0]  buf_q [ABUF];
  logic [BPW-1:0]   head_q;
  logic [CNTW-1:0]  cnt_q;

  logic [NCMP-1:0]  cmp_v;
  logic [TAGW-1:0]  cmp_t [NCMP];
  logic [LANES-1:0] push_en;
  logic [BPW-1:0]   push_pos [LANES];
  int               cap_n, pop_n, room_n, push_n, nlane;

  assign bc_stall_o = cnt_q > CNTW'(ABUF - LANES);

  always_comb begin
    cap_n  = reduce_i ? NARROW : LANES;
    pop_n  = (int'(cnt_q) < cap_n) ? int'(cnt_q) : cap_n;
    room_n = cap_n - pop_n;
    nlane  = 0;
    for (int s = 0; s < LANES; s++) begin
      cmp_t[s] = buf_q[BPW'(int'(head_q) + s)];
      cmp_v[s] = s < pop_n;
    end
    for (int l = 0; l < LANES; l++) begin
      cmp_t[LANES+l] = bc_tag_i[l*TAGW +: TAGW];
      cmp_v[LANES+l] = 1'b0;
      push_en[l]     = 1'b0;
      push_pos[l]    = BPW'(int'(head_q) + int'(cnt_q) + nlane - room_n);
      if (bc_vld_i[l] && !bc_stall_o) begin
        if (nlane < room_n) cmp_v[LANES+l] = 1'b1;
        else                push_en[l]     = 1'b1;
        nlane = nlane + 1;
      end
    end
    push_n = (nlane > room_n) ? nlane - room_n : 0;
  end

  function automatic logic hit(input logic [TAGW-1:0] t, input logic [NCMP-1:0] v,
                               input logic [TAGW-1:0] ct [NCMP]);
    logic h;
    h = 1'b0;
    for (int s = 0; s < NCMP; s++) h = h | (v[s] && ct[s] == t);
    return h;
  endfunction

  logic [DEPTH-1:0] ra_n, rb_n;
  logic             dma, dmb;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      ra_n[i] = ra_q[i] | hit(ta_q[i], cmp_v, cmp_t);
      rb_n[i] = rb_q[i] | hit(tb_q[i], cmp_v, cmp_t);
    end
    dma = hit(disp_tag_a_i, cmp_v, cmp_t);
    dmb = hit(disp_tag_b_i, cmp_v, cmp_t);
  end

  assign rdy_vec_o = vld_q & ra_n & rb_n;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      int c;
      c = 0;
      for (int j = 0; j < DEPTH; j++)
        if (rdy_vec_o[j] && older_q[j][i]) c = c + 1;
      sel_vec_o[i] = rdy_vec_o[i] && (c < IW);
    end
  end

  logic [IDXW-1:0] fidx;
  logic            do_disp;

  always_comb begin
    fidx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!vld_q[i]) fidx = IDXW'(i);
  end

  assign disp_full_o = &vld_q;
  assign do_disp     = disp_vld_i && !disp_full_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      ra_q   <= '0;
      rb_q   <= '0;
      head_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < DEPTH; i++) older_q[i] <= '0;
    end else begin
      vld_q  <= vld_q & ~(issue_go_i ? sel_vec_o : '0);
      ra_q   <= ra_n;
      rb_q   <= rb_n;
      head_q <= head_q + BPW'(pop_n);
      cnt_q  <= CNTW'(int'(cnt_q) - pop_n + push_n);
      if (do_disp) begin
        vld_q[fidx]   <= 1'b1;
        ra_q[fidx]    <= disp_rdy_a_i | dma;
        rb_q[fidx]    <= disp_rdy_b_i | dmb;
        older_q[fidx] <= '0;
        for (int j = 0; j < DEPTH; j++)
          if (IDXW'(j) != fidx) older_q[j][fidx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_disp) begin
      ta_q[fidx] <= disp_tag_a_i;
      tb_q[fidx] <= disp_tag_b_i;
    end
    for (int l = 0; l < LANES; l++)
      if (push_en[l]) buf_q[push_pos[l]] <= bc_tag_i[l*TAGW +: TAGW];
  end
endmodule

// File: rtl/iq_wakeup_chk.sv
module iq_wakeup_chk #(
  parameter int DEPTH  = 32,
  parameter int LANES  = 4,
  parameter int NARROW = 2,
  parameter int ABUF   = 8,
  parameter int IW     = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     reduce,
  input logic [2*LANES-1:0]       cmp_v,
  input logic [DEPTH-1:0]         rdy,
  input logic [DEPTH-1:0]         sel,
  input logic [DEPTH-1:0]         vld,
  input logic                     full,
  input logic                     go,
  input logic [$clog2(ABUF+1)-1:0] cnt
);
  a_r5_lane_cap: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cmp_v) <= (reduce ? NARROW : LANES));
  a_r8_sel_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (sel & ~rdy) == '0);
  a_r8_sel_width: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel) <= IW);
  a_r9_freed: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> ((vld & $past(sel)) == '0));
  a_r2_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !go) |=> full);
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= ABUF);
endmodule

bind iq_wakeup iq_wakeup_chk #(
  .DEPTH(DEPTH), .LANES(LANES), .NARROW(NARROW), .ABUF(ABUF), .IW(IW)
) chk_i (
  .clk(clk_i), .rst_n(rst_ni), .reduce(reduce_i), .cmp_v(cmp_v),
  .rdy(rdy_vec_o), .sel(sel_vec_o), .vld(vld_q), .full(disp_full_o),
  .go(issue_go_i), .cnt(cnt_q)
);

// File: tb/iq_wakeup_tb_top.sv
`timescale 1ns/1ps
module iq_wakeup_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reduce, disp_vld, d_ra, d_rb, go;
  logic [3:0]  bvld;
  logic [5:0]  btag [4];
  logic [5:0]  d_ta, d_tb;
  logic        stall, full;
  logic [31:0] rdy, sel;
  int          total = 0, fails = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  iq_wakeup dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reduce_i(reduce), .bc_vld_i(bvld),
    .bc_tag_i({btag[3], btag[2], btag[1], btag[0]}), .bc_stall_o(stall),
    .disp_vld_i(disp_vld), .disp_tag_a_i(d_ta), .disp_rdy_a_i(d_ra),
    .disp_tag_b_i(d_tb), .disp_rdy_b_i(d_rb), .disp_full_o(full),
    .rdy_vec_o(rdy), .sel_vec_o(sel), .issue_go_i(go)
  );

  bit mv [32], mra [32], mrb [32];
  int mta [32], mtb [32];
  int age [$];
  int abuf [$];

  function automatic bit hitq(int q[$], int t);
    foreach (q[k]) if (q[k] == t) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(string ph, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", ph, what, act, exp);
    end
  endtask

  task automatic idle();
    bvld = '0; disp_vld = 0; go = 0; d_ra = 0; d_rb = 0;
    foreach (btag[l]) btag[l] = '0;
  endtask

  task automatic tick(string ph);
    int cap, pop, room, c, f;
    bit st, ef;
    int ct[$], nl[$], pl[$], na[$];
    logic [31:0] er, es;
    cap = reduce ? 2 : 4;
    st = abuf.size() > 4;
    pop = (abuf.size() < cap) ? abuf.size() : cap;
    for (int s = 0; s < pop; s++) ct.push_back(abuf[s]);
    room = cap - pop;
    if (!st) for (int l = 0; l < 4; l++) if (bvld[l]) nl.push_back(int'(btag[l]));
    foreach (nl[n]) if (n < room) ct.push_back(nl[n]); else pl.push_back(nl[n]);
    er = '0; es = '0;
    for (int i = 0; i < 32; i++)
      er[i] = mv[i] && (mra[i] || hitq(ct, mta[i])) && (mrb[i] || hitq(ct, mtb[i]));
    c = 0;
    foreach (age[k]) if (er[age[k]] && c < 2) begin es[age[k]] = 1'b1; c++; end
    ef = 1'b1;
    for (int i = 0; i < 32; i++) ef &= mv[i];
    #1;
    chk({ph, "/R3"}, "rdy_vec", rdy, er);
    chk({ph, "/R8"}, "sel_vec", sel, es);
    chk({ph, "/R7"}, "stall", 32'(stall), 32'(st));
    chk({ph, "/R2"}, "full", 32'(full), 32'(ef));
    repeat (pop) void'(abuf.pop_front());
    foreach (pl[k]) abuf.push_back(pl[k]);
    for (int i = 0; i < 32; i++) if (mv[i]) begin
      mra[i] |= hitq(ct, mta[i]);
      mrb[i] |= hitq(ct, mtb[i]);
    end
    f = -1;
    if (disp_vld && !ef) for (int i = 31; i >= 0; i--) if (!mv[i]) f = i;
    if (go) begin
      foreach (age[k]) if (!es[age[k]]) na.push_back(age[k]);
      for (int i = 0; i < 32; i++) if (es[i]) mv[i] = 0;
      age = na;
    end
    if (f >= 0) begin
      mv[f] = 1; mta[f] = int'(d_ta); mtb[f] = int'(d_tb);
      mra[f] = d_ra || hitq(ct, mta[f]);
      mrb[f] = d_rb || hitq(ct, mtb[f]);
      age.push_back(f);
    end
    @(negedge clk);
  endtask

  task automatic disp(int a, bit ra, int b, bit rb);
    disp_vld = 1; d_ta = 6'(a); d_ra = ra; d_tb = 6'(b); d_rb = rb;
  endtask

  task automatic bcast4(int base);
    bvld = 4'hF;
    for (int l = 0; l < 4; l++) btag[l] = 6'(base + l);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog R1 actual=hang expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    reduce = 0; d_ta = '0; d_tb = '0; idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick("R1");
    tick("R1");
    for (int i = 0; i < 4; i++) begin idle(); disp(10 + i, 0, 20 + i, i == 0); tick("R2"); end
    idle(); bcast4(10); tick("R4");
    idle(); bcast4(20); go = 1; tick("R9");
    idle(); go = 1; tick("R9"); tick("R9");
    for (int i = 0; i < 4; i++) begin idle(); disp(30 + i, 0, 0, 1); tick("R2"); end
    idle(); reduce = 1; bcast4(30); tick("R5");
    idle(); tick("R6"); tick("R6");
    for (int c = 0; c < 5; c++) begin idle(); bcast4(40 + 4 * (c % 4)); tick("R7"); end
    idle(); tick("R7");
    idle(); reduce = 0; bcast4(12); tick("R6");
    idle(); bvld = 4'b0101; btag[0] = 6'd33; btag[2] = 6'd31; tick("R6");
    idle(); tick("R6");
    idle(); disp(50, 0, 51, 0); bvld = 4'b0011; btag[0] = 6'd50; btag[1] = 6'd51; tick("R10");
    idle(); reduce = 1; disp(52, 0, 53, 1); bcast4(50); btag[3] = 6'd52; tick("R10");
    idle(); tick("R10"); reduce = 0;
    for (int i = 0; i < 5; i++) begin idle(); disp(1, 1, 2, 1); tick("R8"); end
    idle(); tick("R8");
    for (int i = 0; i < 6; i++) begin idle(); go = 1; tick("R8"); end
    for (int i = 0; i < 34; i++) begin idle(); disp(60, 0, 61, 0); tick("R2"); end
    idle(); bvld = 4'b0011; btag[0] = 6'd60; btag[1] = 6'd61; go = 1; disp(62, 1, 62, 1); tick("R9");
    idle(); go = 1; tick("R9");
    for (int c = 0; c < 40; c++) begin idle(); go = 1; tick("R9"); end
    for (int c = 0; c < 600; c++) begin
      idle();
      reduce = ($urandom % 4) == 0;
      bvld = 4'($urandom);
      foreach (btag[l]) btag[l] = 6'($urandom % 48);
      if ($urandom % 3 != 0) disp($urandom % 48, ($urandom % 4) == 0, $urandom % 48, ($urandom % 3) == 0);
      go = ($urandom % 3) != 0;
      tick("R3");
    end
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule